// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block moves words between one device data port and memory. To do this it borrows a bus that it shares with the processor. Software programs a start address, a word count, a direction and a bus-ownership mode, then sets a start bit. The engine then runs through a fixed sequence:

1. It waits for the device to raise its request.
2. It asks for the bus and waits for the grant.
3. It moves words. The address steps up by one word for each word moved, and the count steps down by one.
4. It raises an interrupt when the count reaches zero.

The bus-ownership mode decides how long the engine keeps the bus.

- **Burst:** the engine keeps the bus for the whole count.
- **Cycle-stealing:** the engine gives the bus back after every word.
- **Transparent:** the engine moves a word only in cycles where the processor leaves the bus idle.
- **Block:** the engine holds the bus for a fixed number of words, then gives it back for at least one cycle.

The controller is a single state machine with five states:

| State | Bus request | Purpose |
|---|---|---|
| `ST_IDLE` | low | not busy; waits for a start |
| `ST_WAIT_DEV` | low | waits for the device request |
| `ST_ARB` | high | waits for the grant |
| `ST_MOVE` | high | a word moves in each cycle whose conditions are met |
| `ST_GAP` | low | one enforced idle cycle after a full block |

Its transitions are:

| From | To | Condition |
|---|---|---|
| `ST_IDLE` | `ST_WAIT_DEV` | accepted start |
| `ST_WAIT_DEV` | `ST_ARB` | device request |
| `ST_ARB` | `ST_MOVE` | grant |
| `ST_MOVE` | `ST_IDLE` | last word moved |
| `ST_MOVE` | `ST_WAIT_DEV` | word moved, cycle-stealing mode |
| `ST_MOVE` | `ST_GAP` | block boundary reached, block mode |
| `ST_MOVE` | `ST_MOVE` | otherwise |
| `ST_GAP` | `ST_WAIT_DEV` | always |

Top module: `dma_engine`

## Requirements
- R1: After reset the bus request, the memory strobe and the interrupt are low, and every register reads zero.
- R2: Register offsets are 0 control, 1 address, 2 count and 3 status. A control write sets the mode in bits [2:1] (0 burst, 1 cycle-stealing, 2 transparent, 3 block) and the direction in bit 3. If bit 0 is set and the count is non-zero, the write also starts a transfer. Status bit 0 reads busy until the last word has moved.
- R3: The bus request rises only after the device request is seen. A word moves (memory strobe high) only in a cycle with the bus grant high.
- R4: Each moved word raises the address by one and lowers the count by one. With direction 0, memory is written with the device data (write enable high). With direction 1, memory is read and its data is presented to the device.
- R5: In burst mode the bus request stays high from its first rise until the last word, so it rises exactly once per transfer.
- R6: In cycle-stealing mode one word moves per grant period, and the bus request is low in the cycle after each word.
- R7: In transparent mode no word moves in a cycle where the processor-busy input is high.
- R8: In block mode at most BLOCK_LEN words move per grant period. After a full block that is not the end of the transfer, the bus request is low for at least one cycle.
- R9: After the last word, status bit 1 (done) and the interrupt go high and the bus request is low in the next cycle. The interrupt stays high until status is written with bit 1 set.
- R10: While busy, any register write is ignored and sets status bit 2 (error). Writing status with bit 2 set while not busy clears the error.
- R11: A start with a zero count does not start a transfer and sets the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 2 | register offset |
| reg_wdata | input | DW | register write data |
| reg_rdata | output | DW | register read data, combinational on reg_addr |
| irq | output | 1 | completion interrupt, level |
| dev_req | input | 1 | device transfer request |
| dev_rdata | input | DW | word offered by the device |
| dev_wdata | output | DW | word presented to the device |
| dev_ack | output | 1 | a word moves to or from the device this cycle |
| bus_req | output | 1 | bus ownership request |
| bus_gnt | input | 1 | bus ownership grant |
| cpu_busy | input | 1 | processor is using the bus this cycle |
| mem_en | output | 1 | memory access strobe |
| mem_we | output | 1 | memory write enable |
| mem_addr | output | AW | memory word address |
| mem_wdata | output | DW | memory write data |
| mem_rdata | input | DW | memory read data, same cycle |

## Verification
Each result appears on the outputs at a different time, and the bench samples each one there:

- **Same cycle:** the memory strobe, `dev_ack` and the data paths are combinational in the cycle the word moves. The bench samples them one nanosecond after the falling edge, once that cycle's inputs have been driven.
- **One edge later:** a register write lands at the following rising edge, so readbacks are taken after the next falling edge. The bus request rises one edge after the device request is seen, and it falls one edge after the word that ends a grant period. Done and the interrupt also rise one edge after the last word.
- **Per-cycle monitor:** it compares the bus request in the cycle after a word against the previous cycle's strobe. Whole transfers are judged afterwards by the number of rises of the bus request and by the final address and count.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        XM_BURST  = 2'd0,
        XM_STEAL  = 2'd1,
        XM_TRANSP = 2'd2,
        XM_BLOCK  = 2'd3
    } xfer_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_DEV,
        ST_ARB,
        ST_MOVE,
        ST_GAP
    } eng_state_e;

    localparam logic [1:0] RG_CTRL  = 2'd0;
    localparam logic [1:0] RG_ADDR  = 2'd1;
    localparam logic [1:0] RG_COUNT = 2'd2;
    localparam logic [1:0] RG_STAT  = 2'd3;

    localparam int CB_START = 0;
    localparam int CB_MODE  = 1;
    localparam int CB_DIR   = 3;

    localparam int SB_BUSY  = 0;
    localparam int SB_DONE  = 1;
    localparam int SB_ERR   = 2;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          busy,
    input  logic          word_done,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] cur_count,
    output xfer_mode_e    mode,
    output logic          dir,
    output logic          start_go,
    output logic          last_word,
    output logic          done,
    output logic          err
);

    logic wr_idle;
    logic start_req;
    logic wdata_unused;

    assign wdata_unused = ^reg_wdata;
    assign wr_idle      = reg_wr && !busy;
    assign start_req    = wr_idle && (reg_addr == RG_CTRL) && reg_wdata[CB_START];
    assign start_go     = start_req && (cur_count != '0);
    assign last_word    = (cur_count == CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            cur_count <= '0;
            mode      <= XM_BURST;
            dir       <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else begin
            if (reg_wr && busy) begin
                err <= 1'b1;
            end else if (wr_idle) begin
                case (reg_addr)
                    RG_CTRL: begin
                        mode <= xfer_mode_e'(reg_wdata[CB_MODE +: 2]);
                        dir  <= reg_wdata[CB_DIR];
                        if (start_req && cur_count == '0) begin
                            err <= 1'b1;
                        end
                    end
                    RG_ADDR:  cur_addr  <= reg_wdata[AW-1:0];
                    RG_COUNT: cur_count <= reg_wdata[CW-1:0];
                    RG_STAT: begin
                        if (reg_wdata[SB_DONE]) done <= 1'b0;
                        if (reg_wdata[SB_ERR])  err  <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (word_done) begin
                cur_addr  <= cur_addr + AW'(1);
                cur_count <= cur_count - CW'(1);
                if (last_word) begin
                    done <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RG_CTRL: begin
                reg_rdata[CB_MODE +: 2] = mode;
                reg_rdata[CB_DIR]       = dir;
            end
            RG_ADDR:  reg_rdata[AW-1:0] = cur_addr;
            RG_COUNT: reg_rdata[CW-1:0] = cur_count;
            RG_STAT: begin
                reg_rdata[SB_BUSY] = busy;
                reg_rdata[SB_DONE] = done;
                reg_rdata[SB_ERR]  = err;
            end
            default: ;
        endcase
    end

    // R10: a write while busy leaves the error flag set
    a_r10_busy_write_errs: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && busy) |=> err)
        else $error("R10 write while busy did not set error");

    // R9: done only rises once the count has run out
    a_r9_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (cur_count == '0))
        else $error("R9 done rose with count left");

    // R9: done holds until software clears it
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(reg_wr && reg_addr == RG_STAT && reg_wdata[SB_DONE])) |=> done)
        else $error("R9 done dropped without a clear");

    // R11: a zero count never starts the engine
    a_r11_zero_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && cur_count == '0) |=> !busy)
        else $error("R11 zero count started a transfer");

endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
    import dma_pkg::*;
#(
    parameter int BLOCK_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_go,
    input  xfer_mode_e mode,
    input  logic       last_word,
    input  logic       dev_req,
    input  logic       bus_gnt,
    input  logic       cpu_busy,
    output logic       busy,
    output logic       bus_req,
    output logic       word_done
);

    localparam int BW = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1;

    eng_state_e      state, state_nx;
    logic [BW-1:0]   blk_cnt;
    logic            slot_ok;
    logic            blk_end;

    assign slot_ok = bus_gnt && dev_req && ((mode != XM_TRANSP) || !cpu_busy);
    assign blk_end = (blk_cnt == BW'(BLOCK_LEN - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            blk_cnt <= '0;
        end else begin
            state <= state_nx;
            if (word_done) begin
                blk_cnt <= (blk_end || last_word) ? '0 : blk_cnt + BW'(1);
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start_go) state_nx = ST_WAIT_DEV;
            ST_WAIT_DEV: if (dev_req)  state_nx = ST_ARB;
            ST_ARB:      if (bus_gnt)  state_nx = ST_MOVE;
            ST_MOVE: begin
                if (slot_ok) begin
                    if (last_word) begin
                        state_nx = ST_IDLE;
                    end else if (mode == XM_STEAL) begin
                        state_nx = ST_WAIT_DEV;
                    end else if (mode == XM_BLOCK && blk_end) begin
                        state_nx = ST_GAP;
                    end
                end
            end
            ST_GAP:      state_nx = ST_WAIT_DEV;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = 1'b1;
        bus_req   = 1'b0;
        word_done = 1'b0;
        unique case (state)
            ST_IDLE:     busy = 1'b0;
            ST_WAIT_DEV: ;
            ST_ARB:      bus_req = 1'b1;
            ST_MOVE: begin
                bus_req   = 1'b1;
                word_done = slot_ok;
            end
            ST_GAP:      ;
            default:     busy = 1'b0;
        endcase
    end

    // R6: the bus is handed back right after each stolen word
    a_r6_steal_release: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && mode == XM_STEAL) |=> !bus_req)
        else $error("R6 bus kept after a stolen word");

    // R8: a full block is followed by a released bus
    a_r8_block_release: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && mode == XM_BLOCK && blk_end) |=> !bus_req)
        else $error("R8 bus kept past a block");

    // R9: the final word drops the bus request next cycle
    a_r9_last_release: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && last_word) |=> (!bus_req && !busy))
        else $error("R9 bus kept after the last word");

    // R3: a bus request only follows a device request
    a_r3_req_after_dev: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(dev_req))
        else $error("R3 bus requested without device request");

endmodule

// File: rtl/dma_path.sv
module dma_path #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          dir,
    input  logic          word_done,
    input  logic [AW-1:0] cur_addr,
    input  logic [DW-1:0] dev_rdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] dev_wdata,
    output logic          dev_ack
);

    always_comb begin
        mem_en    = word_done;
        mem_we    = word_done && !dir;
        mem_addr  = cur_addr;
        mem_wdata = dev_rdata;
        dev_wdata = mem_rdata;
        dev_ack   = word_done;
    end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int AW        = 16,
    parameter int CW        = 16,
    parameter int DW        = 32,
    parameter int BLOCK_LEN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    input  logic          dev_req,
    input  logic [DW-1:0] dev_rdata,
    output logic [DW-1:0] dev_wdata,
    output logic          dev_ack,
    output logic          bus_req,
    input  logic          bus_gnt,
    input  logic          cpu_busy,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);

    logic          busy;
    logic          word_done;
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] cur_count;
    xfer_mode_e    mode;
    logic          dir;
    logic          start_go;
    logic          last_word;
    logic          done;
    logic          err;

    dma_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .word_done (word_done),
        .cur_addr  (cur_addr),
        .cur_count (cur_count),
        .mode      (mode),
        .dir       (dir),
        .start_go  (start_go),
        .last_word (last_word),
        .done      (done),
        .err       (err)
    );

    dma_fsm #(.BLOCK_LEN(BLOCK_LEN)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_go  (start_go),
        .mode      (mode),
        .last_word (last_word),
        .dev_req   (dev_req),
        .bus_gnt   (bus_gnt),
        .cpu_busy  (cpu_busy),
        .busy      (busy),
        .bus_req   (bus_req),
        .word_done (word_done)
    );

    dma_path #(.AW(AW), .DW(DW)) u_path (
        .dir       (dir),
        .word_done (word_done),
        .cur_addr  (cur_addr),
        .dev_rdata (dev_rdata),
        .mem_rdata (mem_rdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .dev_wdata (dev_wdata),
        .dev_ack   (dev_ack)
    );

    assign irq = done;

    // R3: memory is touched only while the bus is granted
    a_r3_access_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> bus_gnt)
        else $error("R3 access without grant");

    // R7: transparent transfers avoid processor bus cycles
    a_r7_transp_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mode == XM_TRANSP) |-> !cpu_busy)
        else $error("R7 transparent access in a busy cycle");

    // R10: an error flag is visible in status as soon as it is set
    a_r10_err_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (err && reg_addr == RG_STAT) |-> reg_rdata[SB_ERR])
        else $error("R10 error not reported");

endmodule

// File: tb/dma_engine_bench.sv
`timescale 1ns/100ps
module dma_engine_bench;

    localparam int BLK = 4;
    localparam logic [1:0] A_CTRL = 2'd0, A_ADDR = 2'd1, A_CNT = 2'd2, A_STAT = 2'd3;

    // {mode[2], dir[1], count[8], base[8], expected bus_req rises[8]}
    localparam logic [26:0] VECS [0:7] = '{
        {2'd0, 1'b0, 8'd5, 8'h10, 8'd1},
        {2'd0, 1'b1, 8'd3, 8'h80, 8'd1},
        {2'd1, 1'b0, 8'd4, 8'h20, 8'd4},
        {2'd1, 1'b1, 8'd2, 8'h88, 8'd2},
        {2'd2, 1'b0, 8'd6, 8'h30, 8'd1},
        {2'd2, 1'b1, 8'd4, 8'h90, 8'd1},
        {2'd3, 1'b0, 8'd9, 8'h40, 8'd3},
        {2'd3, 1'b1, 8'd4, 8'hA0, 8'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        dev_req;
    logic [31:0] dev_rdata;
    logic [31:0] dev_wdata;
    logic        dev_ack;
    logic        bus_req;
    logic        bus_gnt;
    logic        cpu_busy = 1'b0;
    logic        mem_en;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;

    logic        dev_req_en = 1'b1;
    logic        gnt_en = 1'b1;
    logic        cb_en = 1'b0;
    logic [1:0]  cb_ph = 2'd0;
    logic [1:0]  mode_cur = 2'd0;
    logic        dir_cur = 1'b0;
    logic [31:0] dev_cnt;
    logic [31:0] mem [0:255];
    logic [255:0] mem_ok;

    int checks = 0;
    int errors = 0;
    int rises = 0;
    int run_len = 0;
    logic prev_req = 1'b0;
    logic prev_en = 1'b0;
    logic prev_irq = 1'b0;

    always #2.5 clk = ~clk;

    assign dev_req   = dev_req_en;
    assign bus_gnt   = bus_req && gnt_en;
    assign dev_rdata = 32'hD000_0000 | dev_cnt;
    assign mem_rdata = mem_ok[mem_addr[7:0]] ? mem[mem_addr[7:0]] : (32'hA500_0000 | {24'd0, mem_addr[7:0]});

    dma_engine u_dma_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .dev_req(dev_req), .dev_rdata(dev_rdata), .dev_wdata(dev_wdata), .dev_ack(dev_ack),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .cpu_busy(cpu_busy),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ok  <= '0;
            dev_cnt <= '0;
        end else begin
            if (mem_en && mem_we) begin
                mem[mem_addr[7:0]]    <= mem_wdata;
                mem_ok[mem_addr[7:0]] <= 1'b1;
            end
            if (dev_ack && !dir_cur) dev_cnt <= dev_cnt + 32'd1;
        end
    end

    always @(negedge clk) begin
        cb_ph    <= (cb_ph == 2'd2) ? 2'd0 : cb_ph + 2'd1;
        cpu_busy <= cb_en && (cb_ph != 2'd2);
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle monitor, sampled 1 ns after the falling edge
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            if (mem_en) begin
                chk("R3 strobe without grant", {31'd0, bus_gnt}, 32'd1);
                if (mode_cur == 2'd2) chk("R7 move in busy cycle", {31'd0, cpu_busy}, 32'd0);
                if (dir_cur) chk("R4 device data from memory", dev_wdata, mem_rdata);
                else chk("R4 memory write enable", {31'd0, mem_we}, 32'd1);
            end
            if (prev_en && mode_cur == 2'd1) chk("R6 request after stolen word", {31'd0, bus_req}, 32'd0);
            if (!bus_req) run_len = 0;
            else if (mem_en) begin
                run_len++;
                if (mode_cur == 2'd3) chk("R8 words per grant", {31'd0, run_len <= BLK}, 32'd1);
            end
            if (bus_req && !prev_req) rises++;
            if (irq && !prev_irq) chk("R9 request after last word", {31'd0, bus_req}, 32'd0);
        end
        prev_req = bus_req;
        prev_en  = mem_en;
        prev_irq = irq;
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int k = 0; k < 400; k++) begin
            rd(A_STAT, v);
            if (!v[0]) break;
        end
    endtask

    task automatic run_case(input int i);
        logic [26:0] v;
        logic [31:0] r;
        logic [31:0] dbase;
        logic [7:0]  n, base;
        string tag;
        v = VECS[i];
        mode_cur = v[26:25]; dir_cur = v[24]; n = v[23:16]; base = v[15:8];
        cb_en = (v[26:25] == 2'd2);
        case (v[26:25])
            2'd0: tag = "R5 burst rises";
            2'd1: tag = "R6 steal rises";
            2'd2: tag = "R7 transparent rises";
            default: tag = "R8 block rises";
        endcase
        dbase = dev_cnt;
        wr(A_ADDR, {24'd0, base});
        wr(A_CNT, {24'd0, n});
        rises = 0;
        wr(A_CTRL, {28'd0, v[24], v[26:25], 1'b1});
        wait_idle();
        chk(tag, rises, {24'd0, v[7:0]});
        rd(A_ADDR, r); chk("R4 final address", r, {24'd0, base} + {24'd0, n});
        rd(A_CNT, r);  chk("R4 final count", r, 32'd0);
        rd(A_STAT, r); chk("R9 done status", r, 32'd2);
        chk("R9 irq raised", {31'd0, irq}, 32'd1);
        if (!v[24]) begin
            for (int k = 0; k < n; k++)
                chk("R4 device word in memory", mem[base + k[7:0]], 32'hD000_0000 | (dbase + k));
        end
        repeat (3) @(negedge clk);
        chk("R9 irq holds", {31'd0, irq}, 32'd1);
        wr(A_STAT, 32'd2);
        rd(A_STAT, r); chk("R9 done cleared", r, 32'd0);
        chk("R9 irq cleared", {31'd0, irq}, 32'd0);
        cb_en = 1'b0;
    endtask

    logic finished = 1'b0;

    initial begin
        logic [31:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 bus_req", {31'd0, bus_req}, 32'd0);
        chk("R1 mem_en", {31'd0, mem_en}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], r); chk("R1 register", r, 32'd0);
        end

        for (int i = 0; i < 8; i++) run_case(i);

        // R2 / R3: no bus request before the device asks
        mode_cur = 2'd0; dir_cur = 1'b0;
        dev_req_en = 1'b0;
        wr(A_ADDR, 32'hC0); wr(A_CNT, 32'd2); wr(A_CTRL, 32'h1);
        repeat (4) @(negedge clk);
        rd(A_STAT, r); chk("R2 busy after start", r, 32'd1);
        chk("R3 no request without device", {31'd0, bus_req}, 32'd0);
        dev_req_en = 1'b1;
        wait_idle();
        rd(A_ADDR, r); chk("R2 transfer ran", r, 32'hC2);
        wr(A_STAT, 32'd2);

        // R10: writes while busy, with the grant withheld
        gnt_en = 1'b0;
        wr(A_ADDR, 32'hD0); wr(A_CNT, 32'd3); wr(A_CTRL, 32'h1);
        repeat (3) @(negedge clk);
        #1;
        chk("R3 request pending", {31'd0, bus_req}, 32'd1);
        chk("R3 no move without grant", {31'd0, mem_en}, 32'd0);
        wr(A_ADDR, 32'h55);
        rd(A_STAT, r); chk("R10 error while busy", r, 32'd5);
        gnt_en = 1'b1;
        wait_idle();
        rd(A_ADDR, r); chk("R10 busy write ignored", r, 32'hD3);
        rd(A_STAT, r); chk("R10 done with error", r, 32'd6);
        wr(A_STAT, 32'd6);
        rd(A_STAT, r); chk("R10 error cleared", r, 32'd0);

        // R11: zero count start
        wr(A_CNT, 32'd0); wr(A_CTRL, 32'h1);
        rd(A_STAT, r); chk("R11 zero count status", r, 32'd4);
        repeat (3) @(negedge clk);
        chk("R11 no bus request", {31'd0, bus_req}, 32'd0);
        wr(A_STAT, 32'd4);
        rd(A_STAT, r); chk("R11 error cleared", r, 32'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule